// File: doc/BRIEF.md
# Triggered Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that exchanges fixed-width frames, 8 bits by default, while running from a continuous clock supplied from outside the chip. Writing the transmit buffer does not start anything by itself. A transfer begins only when a rising edge arrives on a dedicated trigger input and the port is ready. The edge sets a clock-running flag, and from that point the port derives a shift clock from the external clock, either at full rate or at half rate.

Each frame sends the transmit shift register most significant bit first on `sdo_o` and captures `sdi_i` at the same time. A finished byte moves into the receive buffer and raises a receive interrupt pulse. The transmit interrupt is raised either when the buffer is handed to the shift register or when the frame has finished shifting; a select input picks which.

While the clock-running flag stays set, each new transmit-buffer write starts a further frame with no new trigger. If the receive buffer is still unread when the 7th bit of the following frame arrives, an overrun flag is set and that frame raises no receive interrupt.

Top module: `tcs_xcvr`

## Requirements
- R1: A frame carries exactly DATA_W (8) bits, full duplex, most significant bit first. With `sdi_i` looped back from `sdo_o`, the receive buffer ends up equal to the transmitted byte. With the loopback inverted, it ends up equal to the byte's complement.
- R2: A synchronized rising edge of `trig_i` is accepted only when all of these hold: `tx_en_i`=1, `rx_en_i`=1, `tx_full_o`=1 and `sync_o`=0. An edge that is not accepted leaves `sync_o` at 0 and `tx_full_o` at 1.
- R3: Timing is counted in rising edges after `trig_i` is first sampled high. With `div2_i`=0, the hand-off to the shift register (`tx_full_o` falling) takes effect on edge 4 and frame completion on edge 12. With `div2_i`=1, these are edges 5 and 21.
- R4: `sync_o` stays at 1 after a frame ends, until `sync_clr_i` is pulsed. While `sync_o` is 0, no transfer starts and `tx_full_o` remains 1.
- R5: With `tx_irq_sel_i`=0, `tx_irq_o` pulses for one cycle at the hand-off from the transmit buffer to the shift register.
- R6: With `tx_irq_sel_i`=1, `tx_irq_o` pulses for one cycle when the frame has finished shifting out.
- R7: When a received byte moves into the receive buffer, `rx_full_o` becomes 1 and `rx_irq_o` pulses for one cycle, unless an overrun is pending.
- R8: If `rx_full_o` is still 1 when the 7th bit of the next frame is sampled, `overrun_o` is set exactly 7 shift ticks after that frame's hand-off. The frame then raises no `rx_irq_o`.
- R9: A `rx_rd_i` pulse clears `rx_full_o` and `overrun_o`.
- R10: While `sync_o`=1, a transmit-buffer write starts a new frame on a later shift tick with no further trigger.
- R11: After reset, `sync_o`, `tx_full_o`, `rx_full_o`, `overrun_o`, `tx_irq_o` and `rx_irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Continuous external serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Transfer trigger, asynchronous |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable |
| div2_i | input | 1 | 1: shift clock is clk_i divided by two |
| tx_irq_sel_i | input | 1 | Transmit interrupt source: 0 hand-off, 1 completion |
| sync_clr_i | input | 1 | Clears the clock-running flag |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | DATA_W | Transmit buffer write data |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| rx_data_o | output | DATA_W | Receive buffer contents |
| sync_o | output | 1 | Clock-running flag |
| tx_full_o | output | 1 | Transmit buffer holds data |
| rx_full_o | output | 1 | Receive buffer holds unread data |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| overrun_o | output | 1 | Receive overrun flag |

## Verification
The bench builds the block with its defaults, DATA_W=8 and SYNC_STAGES=2. The small frame lets it sweep all 256 byte values. Each value gets a combination of divisor, interrupt source and loopback polarity taken from its low bits, so every data pattern is checked against the arithmetic edge counts for both shift rates. Directed sequences cover:
- refused triggers, each enable withheld in turn;
- a held-off buffer while the flag is clear;
- back-to-back frames without a trigger;
- the overrun path, with its exact offset from hand-off and its suppressed receive interrupt.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic {SH_IDLE = 1'b0, SH_RUN = 1'b1} sh_state_e;

  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tcs_clk_gate.sv
module tcs_clk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic arm_ok_i,
  input  logic clr_i,
  input  logic div2_i,
  output logic sync_o,
  output logic tick_o
);
  logic [SYNC_STAGES:0] trig_sh_q;
  logic                 sync_q, ph_q, accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_sh_q <= '0;
    else         trig_sh_q <= {trig_sh_q[SYNC_STAGES-1:0], trig_i};
  end

  // edge seen on the synchronized copy, one stage behind for the compare
  assign accept = trig_sh_q[SYNC_STAGES-1] & ~trig_sh_q[SYNC_STAGES] & arm_ok_i & ~sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      ph_q   <= 1'b0;
    end else begin
      if (accept)     sync_q <= 1'b1;
      else if (clr_i) sync_q <= 1'b0;
      ph_q <= sync_q ? ~ph_q : 1'b0;
    end
  end

  assign sync_o = sync_q;
  assign tick_o = sync_q & (div2_i ? ph_q : 1'b1);
endmodule

// File: rtl/tcs_tx.sv
module tcs_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              irq_sel_i,
  output logic              sdo_o,
  output logic              full_o,
  output logic              smp_o,
  output logic              pre_last_o,
  output logic              done_o,
  output logic              irq_o
);
  import tcs_pkg::*;
  localparam int CW = cnt_w(DATA_W);

  sh_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] buf_q, tsr_q;
  logic              full_q, irq_q, load, smp, last;

  assign load = tick_i & (state_q == SH_IDLE) & full_q;
  assign smp  = tick_i & (state_q == SH_RUN);
  assign last = smp & (cnt_q == CW'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      cnt_q   <= '0;
      buf_q   <= '0;
      tsr_q   <= '0;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (load) begin
        state_q <= SH_RUN;
        cnt_q   <= '0;
        tsr_q   <= buf_q;
      end else if (smp) begin
        cnt_q <= cnt_q + 1'b1;
        tsr_q <= {tsr_q[DATA_W-2:0], 1'b0};
        if (last) state_q <= SH_IDLE;
      end
      if (wr_i) buf_q <= data_i;
      if (wr_i)      full_q <= 1'b1;
      else if (load) full_q <= 1'b0;
      irq_q <= irq_sel_i ? last : load;
    end
  end

  assign sdo_o      = tsr_q[DATA_W-1];
  assign full_o     = full_q;
  assign smp_o      = smp;
  assign pre_last_o = smp & (cnt_q == CW'(DATA_W - 2));
  assign done_o     = last;
  assign irq_o      = irq_q;
endmodule

// File: rtl/tcs_rx.sv
module tcs_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_i,
  input  logic              pre_last_i,
  input  logic              done_i,
  input  logic              sdi_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              irq_o
);
  logic [DATA_W-2:0] rsr_q;
  logic [DATA_W-1:0] buf_q;
  logic              full_q, ovr_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsr_q  <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (smp_i) rsr_q <= {rsr_q[DATA_W-3:0], sdi_i};
      if (done_i) buf_q <= {rsr_q, sdi_i};
      if (done_i)    full_q <= 1'b1;
      else if (rd_i) full_q <= 1'b0;
      if (pre_last_i && full_q) ovr_q <= 1'b1;
      else if (rd_i)            ovr_q <= 1'b0;
      irq_q <= done_i & ~ovr_q;
    end
  end

  assign data_o = buf_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/tcs_xcvr.sv
module tcs_xcvr #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              div2_i,
  input  logic              tx_irq_sel_i,
  input  logic              sync_clr_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sync_o,
  output logic              tx_full_o,
  output logic              rx_full_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              overrun_o
);
  logic tick, smp, pre_last, done, tx_full;

  tcs_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig_i),
    .arm_ok_i (tx_en_i & rx_en_i & tx_full),
    .clr_i    (sync_clr_i),
    .div2_i   (div2_i),
    .sync_o   (sync_o),
    .tick_o   (tick)
  );

  tcs_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .wr_i       (tx_wr_i),
    .data_i     (tx_data_i),
    .irq_sel_i  (tx_irq_sel_i),
    .sdo_o      (sdo_o),
    .full_o     (tx_full),
    .smp_o      (smp),
    .pre_last_o (pre_last),
    .done_o     (done),
    .irq_o      (tx_irq_o)
  );

  tcs_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_i      (smp),
    .pre_last_i (pre_last),
    .done_i     (done),
    .sdi_i      (sdi_i),
    .rd_i       (rx_rd_i),
    .data_o     (rx_data_o),
    .full_o     (rx_full_o),
    .ovr_o      (overrun_o),
    .irq_o      (rx_irq_o)
  );

  assign tx_full_o = tx_full;
endmodule

// File: rtl/tcs_xcvr_chk.sv
module tcs_xcvr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic rx_en_i,
  input logic sync_clr_i,
  input logic rx_rd_i,
  input logic sync_o,
  input logic tx_full_o,
  input logic rx_full_o,
  input logic tx_irq_o,
  input logic rx_irq_o,
  input logic overrun_o
);
  a_r2_arm_conditions: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(tx_en_i && rx_en_i && tx_full_o));

  a_r4_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && !sync_clr_i) |=> sync_o);

  a_r4_no_handoff_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_full_o) |-> $past(sync_o));

  a_r5_tx_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o);

  a_r7_rx_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o);

  a_r7_irq_with_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_full_o);

  a_r8_no_irq_on_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> !overrun_o);

  a_r9_overrun_clear_by_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(overrun_o) |-> $past(rx_rd_i));
endmodule

bind tcs_xcvr tcs_xcvr_chk u_chk (.*);

// File: tb/tcs_xcvr_tb.sv
module tcs_xcvr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic trig = 0, tx_en = 1, rx_en = 1, div2 = 0, tx_sel = 0, sync_clr = 0;
  logic tx_wr = 0, rx_rd = 0, sdi_inv = 0;
  logic [W-1:0] tx_data = '0;
  logic sdo, sync, tx_full, rx_full, tx_irq, rx_irq, ovr;
  logic [W-1:0] rx_data;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcs_xcvr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .div2_i(div2), .tx_irq_sel_i(tx_sel), .sync_clr_i(sync_clr), .tx_wr_i(tx_wr),
    .tx_data_i(tx_data), .rx_rd_i(rx_rd), .sdi_i(sdo ^ sdi_inv), .sdo_o(sdo),
    .rx_data_o(rx_data), .sync_o(sync), .tx_full_o(tx_full), .rx_full_o(rx_full),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .overrun_o(ovr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_tx(input logic [W-1:0] d);
    tx_data = d; tx_wr = 1; @(negedge clk); tx_wr = 0;
  endtask

  task automatic rd_rx();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  task automatic pulse_trig();
    trig = 1; repeat (3) @(negedge clk); trig = 0; repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [W-1:0] d, input bit inv, input bit d2, input bit sel);
    int n, n_tx, n_rx, n_ld;
    div2 = d2; tx_sel = sel; sdi_inv = inv;
    sync_clr = 1; @(negedge clk); sync_clr = 0;
    wr_tx(d);
    trig = 1; n = 0; n_tx = 0; n_rx = 0; n_ld = 0;
    while (n_rx == 0 && n < 60) begin
      @(negedge clk); n++;
      if (n == 3) trig = 0;
      if (tx_irq && n_tx == 0) n_tx = n;
      if (!tx_full && n_ld == 0) n_ld = n;
      if (rx_irq) n_rx = n;
    end
    trig = 0;
    chk("R1 received byte", int'(rx_data), int'(d ^ {W{inv}}));
    chk("R3 hand-off edge", n_ld, d2 ? 5 : 4);
    chk("R3 completion edge", n_rx, d2 ? 21 : 12);
    if (sel) chk("R6 tx irq at completion", n_tx, d2 ? 21 : 12);
    else     chk("R5 tx irq at hand-off", n_tx, d2 ? 5 : 4);
    rd_rx();
    chk("R9 read clears rx_full", int'(rx_full), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int m, m_ld, m_ovr, m_irq;
    repeat (3) @(negedge clk);
    chk("R11 sync", int'(sync), 0);
    chk("R11 tx_full", int'(tx_full), 0);
    chk("R11 rx_full", int'(rx_full), 0);
    chk("R11 overrun", int'(ovr), 0);
    chk("R11 irqs", int'(tx_irq | rx_irq), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: refused triggers
    pulse_trig();
    chk("R2 empty buffer refuses", int'(sync), 0);
    tx_en = 0; wr_tx(8'h5A); pulse_trig();
    chk("R2 tx disabled refuses", int'(sync), 0);
    chk("R2 tx disabled keeps buffer", int'(tx_full), 1);
    tx_en = 1; rx_en = 0; pulse_trig();
    chk("R2 rx disabled refuses", int'(sync), 0);
    chk("R2 rx disabled keeps buffer", int'(tx_full), 1);
    rx_en = 1;
    repeat (20) @(negedge clk);
    chk("R4 no transfer while flag clear", int'(tx_full), 1);
    pulse_trig();
    chk("R2 accepted trigger sets flag", int'(sync), 1);
    repeat (10) @(negedge clk);
    chk("R7 rx_full after frame", int'(rx_full), 1);
    chk("R1 first byte", int'(rx_data), 8'h5A);
    chk("R4 flag held after frame", int'(sync), 1);
    rd_rx();

    // R8 / R10: second frame while buffer unread
    frame(8'hA5, 0, 0, 0);
    sync_clr = 1; @(negedge clk); sync_clr = 0;
    wr_tx(8'hC3); trig = 1; repeat (3) @(negedge clk); trig = 0;
    repeat (15) @(negedge clk);
    chk("R7 rx_full set", int'(rx_full), 1);
    chk("R8 no overrun yet", int'(ovr), 0);
    wr_tx(8'h3C);
    m = 0; m_ld = 0; m_ovr = 0; m_irq = 0;
    while (m < 30) begin
      @(negedge clk); m++;
      if (!tx_full && m_ld == 0) m_ld = m;
      if (ovr && m_ovr == 0) m_ovr = m;
      if (rx_irq) m_irq = 1;
    end
    chk("R10 untriggered hand-off", int'(m_ld > 0), 1);
    chk("R8 overrun offset", m_ovr - m_ld, 7);
    chk("R8 no rx irq on overrun", m_irq, 0);
    chk("R4 flag still set", int'(sync), 1);
    rd_rx();
    chk("R9 read clears overrun", int'(ovr), 0);
    chk("R9 read clears rx_full", int'(rx_full), 0);

    // sweep all byte values
    for (int v = 0; v < 256; v++) frame(W'(v), v[2], v[0], v[1]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule